// File: doc/BRIEF.md
# Shared L2 Registry Bank

This block is one bank of a shared second-level cache where every stored word doubles as its own directory entry. Each entry carries a single state bit. When the bit is clear, the word field holds ordinary data that any number of first-level caches may copy without telling the bank. When the bit is set, the word is owned: the data field then holds the identifier of the core that registered it instead of data. No sharer list or other directory storage exists beyond that bit.

First-level controllers send requests over one valid/ready channel, one per cycle. There are three request kinds:
- A read of a data-holding word is answered from the bank.
- A read of an owned word is redirected to the owning core, which supplies the data itself.
- A registration takes ownership and is acknowledged.

A writeback from the current owner stores the data and clears ownership. Every response comes out one cycle after its request is accepted, so responses stay in request order.

Top module: `registry_l2`

## Requirements
- R1: While `rst` is high, `reqReady` and all three response valids are low. After reset, every entry holds data 0 and is not owned, so a read of any address returns 0.
- R2: An accepted read (op code 2'b00) of an unowned entry raises `dataValid` in the following cycle. `dataWord` carries the stored word, `dataCore` the requester and `dataAddr` the address. No forward is raised.
- R3: An accepted registration (op code 2'b01) raises `ackValid` in the following cycle, with the requester on `ackCore` and the address on `ackAddr`. The entry becomes owned by the requester.
- R4: An accepted read of an owned entry raises `fwdValid` in the following cycle. `fwdOwner` carries the stored owner id, `fwdRequester` the reader and `fwdAddr` the address. `dataValid` stays low.
- R5: An accepted writeback (op code 2'b10) whose core equals the stored owner stores `reqData`, makes the entry unowned again, and raises `ackValid` in the following cycle.
- R6: A writeback from a core other than the owner, or a writeback to an unowned entry, produces no response and changes neither the stored word nor the ownership.
- R7: A registration of an entry already owned by another core replaces the owner id. Only the new owner is acknowledged, and the earlier owner receives nothing.
- R8: At most one of `ackValid`, `dataValid` and `fwdValid` is high in any cycle. None is high in a cycle that follows a cycle with no accepted request.
- R9: Reads of an unowned entry from several cores each return the same data and leave the entry unchanged.
- R10: `reqReady` is high in every cycle after the first clock edge with reset low. Back-to-back requests are accepted on consecutive cycles, and their responses appear in the same order.
- R11: The reserved op code 2'b11 produces no response and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bank can accept a request |
| reqOp | input | 2 | Request kind: 00 read, 01 register, 10 writeback, 11 reserved |
| reqCore | input | CORE_W (2) | Requesting core id |
| reqAddr | input | ADDR_W (4) | Entry index |
| reqData | input | DATA_W (16) | Writeback data |
| ackValid | output | 1 | Acknowledge of a registration or a writeback |
| ackCore | output | CORE_W (2) | Core being acknowledged |
| ackAddr | output | ADDR_W (4) | Address acknowledged |
| dataValid | output | 1 | Data response from the bank |
| dataCore | output | CORE_W (2) | Core receiving the data |
| dataAddr | output | ADDR_W (4) | Address of the data |
| dataWord | output | DATA_W (16) | Returned data |
| fwdValid | output | 1 | Read redirected to the owning core |
| fwdOwner | output | CORE_W (2) | Core that must supply the data |
| fwdRequester | output | CORE_W (2) | Core that asked for it |
| fwdAddr | output | ADDR_W (4) | Address being read |

## Verification
Every response (ack, data or forward) is registered and is due exactly one clock edge after the edge that accepts its request. `reqReady` is due one edge after reset is released. The bench drives each request on a falling edge and samples all three response channels 2 ns after the next rising edge. At that point it compares which channel is valid, and the fields of that channel, with the result the requirements predict. For the ignored cases (a writeback from a foreign core, a writeback to an unowned entry, the reserved op code), the bench checks that no channel fires. A later read then shows that the entry was left untouched.

// File: rtl/registry_pkg.sv
package registry_pkg;

  typedef enum logic [1:0] {
    OP_READ      = 2'b00,
    OP_REGISTER  = 2'b01,
    OP_WRITEBACK = 2'b10,
    OP_RESERVED  = 2'b11
  } reqOp_e;

  // Strobes from control to datapath for the accepted request
  typedef struct packed {
    logic setOwner;   // overwrite word with requester id, mark owned
    logic storeData;  // overwrite word with data, mark unowned
    logic sendAck;
    logic sendData;
    logic sendFwd;
  } ctrlStrobes_t;

endpackage

// File: rtl/registry_ctrl.sv
module registry_ctrl
  import registry_pkg::*;
#(
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqFire,
  input  logic [1:0]        reqOp,
  input  logic [CORE_W-1:0] reqCore,
  input  logic              entryOwned,
  input  logic [CORE_W-1:0] entryOwner,
  output logic              reqReady,
  output ctrlStrobes_t      strb
);

  always_ff @(posedge clk) begin
    if (rst) reqReady <= 1'b0;
    else     reqReady <= 1'b1;
  end

  logic ownerHit;
  assign ownerHit = entryOwned && (entryOwner == reqCore);

  always_comb begin
    strb = '0;
    if (reqFire) begin
      case (reqOp_e'(reqOp))
        OP_READ: begin
          strb.sendData = !entryOwned;
          strb.sendFwd  = entryOwned;
        end
        OP_REGISTER: begin
          strb.setOwner = 1'b1;
          strb.sendAck  = 1'b1;
        end
        OP_WRITEBACK: begin
          strb.storeData = ownerHit;
          strb.sendAck   = ownerHit;
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/registry_dp.sv
module registry_dp
  import registry_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CORE_W = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              entryOwned,
  output logic [CORE_W-1:0] entryOwner,
  output logic              ackValid,
  output logic [CORE_W-1:0] ackCore,
  output logic [ADDR_W-1:0] ackAddr,
  output logic              dataValid,
  output logic [CORE_W-1:0] dataCore,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWord,
  output logic              fwdValid,
  output logic [CORE_W-1:0] fwdOwner,
  output logic [CORE_W-1:0] fwdRequester,
  output logic [ADDR_W-1:0] fwdAddr
);

  // Word field holds either data or, when owned, the owner id in its low bits
  logic [DATA_W-1:0] wordField [DEPTH];
  logic [DEPTH-1:0]  ownedBit;
  logic [DATA_W-1:0] entryWord;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic sel;
    assign sel = (reqAddr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        wordField[i] <= '0;
        ownedBit[i]  <= 1'b0;
      end else if (sel && strb.setOwner) begin
        wordField[i] <= DATA_W'(reqCore);
        ownedBit[i]  <= 1'b1;
      end else if (sel && strb.storeData) begin
        wordField[i] <= reqData;
        ownedBit[i]  <= 1'b0;
      end
    end
  end

  assign entryWord  = wordField[reqAddr];
  assign entryOwned = ownedBit[reqAddr];
  assign entryOwner = entryWord[CORE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ackValid     <= 1'b0;
      ackCore      <= '0;
      ackAddr      <= '0;
      dataValid    <= 1'b0;
      dataCore     <= '0;
      dataAddr     <= '0;
      dataWord     <= '0;
      fwdValid     <= 1'b0;
      fwdOwner     <= '0;
      fwdRequester <= '0;
      fwdAddr      <= '0;
    end else begin
      ackValid  <= strb.sendAck;
      dataValid <= strb.sendData;
      fwdValid  <= strb.sendFwd;
      if (strb.sendAck) begin
        ackCore <= reqCore;
        ackAddr <= reqAddr;
      end
      if (strb.sendData) begin
        dataCore <= reqCore;
        dataAddr <= reqAddr;
        dataWord <= entryWord;
      end
      if (strb.sendFwd) begin
        fwdOwner     <= entryOwner;
        fwdRequester <= reqCore;
        fwdAddr      <= reqAddr;
      end
    end
  end

endmodule

// File: rtl/registry_l2.sv
module registry_l2
  import registry_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              ackValid,
  output logic [CORE_W-1:0] ackCore,
  output logic [ADDR_W-1:0] ackAddr,
  output logic              dataValid,
  output logic [CORE_W-1:0] dataCore,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWord,
  output logic              fwdValid,
  output logic [CORE_W-1:0] fwdOwner,
  output logic [CORE_W-1:0] fwdRequester,
  output logic [ADDR_W-1:0] fwdAddr
);

  ctrlStrobes_t      strb;
  logic              entryOwned;
  logic [CORE_W-1:0] entryOwner;
  logic              reqFire;

  assign reqFire = reqValid && reqReady;

  registry_ctrl #(.CORE_W(CORE_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .reqFire    (reqFire),
    .reqOp      (reqOp),
    .reqCore    (reqCore),
    .entryOwned (entryOwned),
    .entryOwner (entryOwner),
    .reqReady   (reqReady),
    .strb       (strb)
  );

  registry_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CORE_W(CORE_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .reqCore      (reqCore),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .entryOwned   (entryOwned),
    .entryOwner   (entryOwner),
    .ackValid     (ackValid),
    .ackCore      (ackCore),
    .ackAddr      (ackAddr),
    .dataValid    (dataValid),
    .dataCore     (dataCore),
    .dataAddr     (dataAddr),
    .dataWord     (dataWord),
    .fwdValid     (fwdValid),
    .fwdOwner     (fwdOwner),
    .fwdRequester (fwdRequester),
    .fwdAddr      (fwdAddr)
  );

endmodule

// File: rtl/registry_l2_chk.sv
module registry_l2_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqOp,
  input logic [CORE_W-1:0] reqCore,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic              ackValid,
  input logic [CORE_W-1:0] ackCore,
  input logic [ADDR_W-1:0] ackAddr,
  input logic              dataValid,
  input logic [CORE_W-1:0] dataCore,
  input logic [ADDR_W-1:0] dataAddr,
  input logic [DATA_W-1:0] dataWord,
  input logic              fwdValid,
  input logic [CORE_W-1:0] fwdOwner,
  input logic [CORE_W-1:0] fwdRequester,
  input logic [ADDR_W-1:0] fwdAddr
);

  logic accepted;
  assign accepted = reqValid && reqReady;

  a_r8_single_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ackValid, dataValid, fwdValid}));

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> !(ackValid || dataValid || fwdValid));

  a_r3_register_acked: assert property (@(posedge clk) disable iff (rst)
    (accepted && reqOp == 2'b01) |=>
      (ackValid && ackCore == $past(reqCore) && ackAddr == $past(reqAddr)));

  a_r2_read_answered: assert property (@(posedge clk) disable iff (rst)
    (accepted && reqOp == 2'b00) |=>
      ((dataValid && dataCore == $past(reqCore) && dataAddr == $past(reqAddr)) ||
       (fwdValid && fwdRequester == $past(reqCore) && fwdAddr == $past(reqAddr))));

  a_r11_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (accepted && reqOp == 2'b11) |=> !(ackValid || dataValid || fwdValid));

  a_r10_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    !rst |=> reqReady);

endmodule

bind registry_l2 registry_l2_chk #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .DEPTH(DEPTH)
) chk_i (.*);

// File: tb/registry_l2_tb.sv
module registry_l2_tb_top;

  localparam int NUM_CORES = 4;
  localparam int DATA_W    = 16;
  localparam int DEPTH     = 16;
  localparam int CORE_W    = 2;
  localparam int ADDR_W    = 4;

  typedef struct packed {
    logic [1:0]        op;
    logic [CORE_W-1:0] core;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [1:0]        kind;    // 0 none, 1 ack, 2 data, 3 fwd
    logic [CORE_W-1:0] owner;   // expected fwdOwner
    logic [DATA_W-1:0] expData; // expected dataWord
    logic [3:0]        req;     // requirement number
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 4'd3,  16'h0000, 2'd2, 2'd0, 16'h0000, 4'd1},  // R1 reset word 0
    '{2'd2, 2'd1, 4'd3,  16'hAAAA, 2'd0, 2'd0, 16'h0000, 4'd6},  // R6 wb to unowned
    '{2'd0, 2'd2, 4'd3,  16'h0000, 2'd2, 2'd0, 16'h0000, 4'd6},  // R6 untouched
    '{2'd1, 2'd2, 4'd5,  16'h0000, 2'd1, 2'd0, 16'h0000, 4'd3},  // R3 register
    '{2'd0, 2'd0, 4'd5,  16'h0000, 2'd3, 2'd2, 16'h0000, 4'd4},  // R4 forward
    '{2'd2, 2'd1, 4'd5,  16'h1234, 2'd0, 2'd0, 16'h0000, 4'd6},  // R6 foreign wb
    '{2'd0, 2'd3, 4'd5,  16'h0000, 2'd3, 2'd2, 16'h0000, 4'd6},  // R6 owner kept
    '{2'd2, 2'd2, 4'd5,  16'h1234, 2'd1, 2'd0, 16'h0000, 4'd5},  // R5 owner wb
    '{2'd0, 2'd0, 4'd5,  16'h0000, 2'd2, 2'd0, 16'h1234, 4'd5},  // R5 data back
    '{2'd0, 2'd3, 4'd5,  16'h0000, 2'd2, 2'd0, 16'h1234, 4'd9},  // R9 second reader
    '{2'd1, 2'd1, 4'd7,  16'h0000, 2'd1, 2'd0, 16'h0000, 4'd3},  // R3
    '{2'd1, 2'd3, 4'd7,  16'h0000, 2'd1, 2'd0, 16'h0000, 4'd7},  // R7 re-register
    '{2'd0, 2'd0, 4'd7,  16'h0000, 2'd3, 2'd3, 16'h0000, 4'd7},  // R7 new owner
    '{2'd2, 2'd1, 4'd7,  16'h5555, 2'd0, 2'd0, 16'h0000, 4'd7},  // R7 old owner wb
    '{2'd0, 2'd2, 4'd7,  16'h0000, 2'd3, 2'd3, 16'h0000, 4'd7},  // R7 still owned
    '{2'd3, 2'd0, 4'd5,  16'hFFFF, 2'd0, 2'd0, 16'h0000, 4'd11}, // R11 reserved
    '{2'd0, 2'd1, 4'd5,  16'h0000, 2'd2, 2'd0, 16'h1234, 4'd11}, // R11 no change
    '{2'd2, 2'd3, 4'd7,  16'hBEEF, 2'd1, 2'd0, 16'h0000, 4'd5},  // R5
    '{2'd0, 2'd1, 4'd7,  16'h0000, 2'd2, 2'd0, 16'hBEEF, 4'd10}, // R10 in order
    '{2'd0, 2'd2, 4'd15, 16'h0000, 2'd2, 2'd0, 16'h0000, 4'd2},  // R2 top address
    '{2'd1, 2'd0, 4'd15, 16'h0000, 2'd1, 2'd0, 16'h0000, 4'd3},  // R3 core 0
    '{2'd0, 2'd1, 4'd15, 16'h0000, 2'd3, 2'd0, 16'h0000, 4'd4}   // R4 owner id 0
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [1:0]        reqOp = '0;
  logic [CORE_W-1:0] reqCore = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic              ackValid, dataValid, fwdValid;
  logic [CORE_W-1:0] ackCore, dataCore, fwdOwner, fwdRequester;
  logic [ADDR_W-1:0] ackAddr, dataAddr, fwdAddr;
  logic [DATA_W-1:0] dataWord;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  registry_l2 #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqCore(reqCore), .reqAddr(reqAddr), .reqData(reqData),
    .ackValid(ackValid), .ackCore(ackCore), .ackAddr(ackAddr),
    .dataValid(dataValid), .dataCore(dataCore), .dataAddr(dataAddr),
    .dataWord(dataWord), .fwdValid(fwdValid), .fwdOwner(fwdOwner),
    .fwdRequester(fwdRequester), .fwdAddr(fwdAddr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic applyVec(vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = v.op;
    reqCore  = v.core;
    reqAddr  = v.addr;
    reqData  = v.wdata;
    @(posedge clk);
    #2;
    chk(tag, "channels {ack,data,fwd}", {29'd0, ackValid, dataValid, fwdValid},
        {29'd0, v.kind == 2'd1, v.kind == 2'd2, v.kind == 2'd3});
    if (v.kind == 2'd1) begin
      chk(tag, "ackCore", 32'(ackCore), 32'(v.core));
      chk(tag, "ackAddr", 32'(ackAddr), 32'(v.addr));
    end else if (v.kind == 2'd2) begin
      chk(tag, "dataCore", 32'(dataCore), 32'(v.core));
      chk(tag, "dataAddr", 32'(dataAddr), 32'(v.addr));
      chk(tag, "dataWord", 32'(dataWord), 32'(v.expData));
    end else if (v.kind == 2'd3) begin
      chk(tag, "fwdOwner", 32'(fwdOwner), 32'(v.owner));
      chk(tag, "fwdRequester", 32'(fwdRequester), 32'(v.core));
      chk(tag, "fwdAddr", 32'(fwdAddr), 32'(v.addr));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 / R10: quiet during reset
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {29'd0, ackValid, dataValid, fwdValid}, 32'd0);
    chk("R10", "reqReady in reset", 32'(reqReady), 32'd0);
    rst = 1'b0;
    @(posedge clk);
    #2;
    chk("R10", "reqReady after reset", 32'(reqReady), 32'd1);
    // R8: idle cycle produces nothing
    @(posedge clk);
    #2;
    chk("R8", "idle outputs", {29'd0, ackValid, dataValid, fwdValid}, 32'd0);

    for (int i = 0; i < NV; i++) applyVec(VECS[i]);

    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #2;
    chk("R8", "outputs after last request", {29'd0, ackValid, dataValid, fwdValid}, 32'd0);

    // R1: second reset clears ownership and data
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady held low", 32'(reqReady), 32'd0);
    rst = 1'b0;
    @(posedge clk);
    applyVec('{2'd0, 2'd2, 4'd7, 16'h0000, 2'd2, 2'd0, 16'h0000, 4'd1});
    applyVec('{2'd0, 2'd3, 4'd15, 16'h0000, 2'd2, 2'd0, 16'h0000, 4'd1});
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule